// File: doc/BRIEF.md
# Coordinate Coincidence Screening Engine

This engine screens a group of targets for possible collisions by finding every pair of targets whose x, y and z coordinates are all identical. Software or an upstream block first fills the engine's coordinate store through a simple load port, one coordinate per cycle. It then pulses a start strobe. The engine works on one axis at a time, in the order x, then y, then z. For each axis it clears a parallel-match array and writes that axis's coordinate of every target into it. It then searches the array once with each target's own coordinate, which gives one match vector per target for that axis. Each target's vectors are ANDed across the three axes. A bit that is still set at position j after all three axes marks target j as a coincidence partner.

When the run completes, the engine publishes one partner mask per target, with the target's own bit removed. It also publishes a global any-collision flag and a frozen count of the cycles the run took. Results stay unchanged until the next accepted start.

Top module: `coord_screen_top`

## Requirements
- R1: When `loadEn` is high and the engine is idle, `loadData` is stored as the coordinate of target `loadIdx` on the axis chosen by `loadAxis` (0 = x, 1 = y, 2 = z; the value 3 stores nothing). Loads presented while `busy` is high are ignored and do not affect the current run or the next one.
- R2: A `start` pulse sampled while idle raises `busy` at the next clock edge. `busy` stays high for exactly 3*(2*NUM_TGT+1)+1 clock edges, which is 100 for 16 targets. `done` rises on the same edge that `busy` falls.
- R3: After a run, bit j of target i's partner mask (`partnerMask` bit i*NUM_TGT+j) is 1 exactly when i differs from j and targets i and j have equal x, equal y and equal z coordinates. Equality on only one or two axes leaves the bit at 0.
- R4: The bit of a target's own position in its partner mask (bit i*NUM_TGT+i) always reads 0.
- R5: After a run, `anyCollision` equals the OR of all bits of `partnerMask`.
- R6: `cycleCount` is cleared when a start is accepted. It then increments on every busy cycle, holding 100 for 16 targets when `done` rises, and stays frozen while the engine is idle.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The current run continues, and its length and count are unchanged.
- R8: `partnerMask`, `anyCollision` and `done` hold their values until the next accepted start. `done` falls at the edge that accepts a new start, and the masks change only when that run finishes.
- R9: After reset, `busy`, `done`, `anyCollision`, `cycleCount` and every bit of `partnerMask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Write one coordinate into the store |
| loadAxis | input | 2 | Axis selector: 0 x, 1 y, 2 z, 3 none |
| loadIdx | input | $clog2(NUM_TGT) | Target index of the coordinate written |
| loadData | input | COORD_W | Coordinate value |
| start | input | 1 | Begin a screening run (single-cycle pulse) |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High from the end of a run until the next start |
| partnerMask | output | NUM_TGT*NUM_TGT | Target i's partners in bits i*NUM_TGT +: NUM_TGT |
| anyCollision | output | 1 | At least one coincident pair was found |
| cycleCount | output | CNT_W | Cycles taken by the latest run |

## Verification
Every output is registered. `busy` and a cleared `cycleCount` appear one edge after an accepted start. The masks, `anyCollision` and `done` appear together exactly 100 edges after that start, and `cycleCount` reads 100 at the same moment. A reference model in the bench advances on the same rising edge as the design and derives its expected masks from its own copy of the loaded coordinates. The outputs are compared with the model at every falling edge, so every intermediate cycle of a run is checked as well as the final one. Further targeted checks sample after the finishing edge. They cover self-bit clearing, result holding, starts issued mid-run and loads issued mid-run.

// File: rtl/coord_screen_pkg.sv
package coord_screen_pkg;

  typedef enum logic [1:0] {
    AX_X = 2'd0,
    AX_Y = 2'd1,
    AX_Z = 2'd2
  } axisT;

  // strobes from control to datapath
  typedef struct packed {
    logic initAcc;
    logic clearCam;
    logic writeCam;
    logic searchCam;
    logic publish;
    axisT axis;
  } ctrlStrobeT;

endpackage

// File: rtl/coord_cam.sv
module coord_cam #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] key,
  output logic [DEPTH-1:0] hitVec
);

  logic [WIDTH-1:0] entry [DEPTH];
  logic [DEPTH-1:0] valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid <= '0;
      for (int i = 0; i < DEPTH; i++) entry[i] <= '0;
    end else if (clear) begin
      valid <= '0;
    end else if (wrEn) begin
      entry[wrIdx] <= wrData;
      valid[wrIdx] <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gMatch
    assign hitVec[g] = valid[g] && (entry[g] == key);
  end

endmodule

// File: rtl/coord_screen_ctrl.sv
module coord_screen_ctrl
  import coord_screen_pkg::*;
#(
  parameter int NUM_TGT = 16,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(NUM_TGT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output ctrlStrobeT       strobe,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cycleCount
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TGT - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_CLEAR, ST_WRITE, ST_SEARCH, ST_FINISH} stateT;

  stateT state;
  axisT  axis;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      axis       <= AX_X;
      idx        <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      cycleCount <= '0;
    end else begin
      if (busy) cycleCount <= cycleCount + 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          state      <= ST_CLEAR;
          axis       <= AX_X;
          idx        <= '0;
          busy       <= 1'b1;
          done       <= 1'b0;
          cycleCount <= '0;
        end
        ST_CLEAR: begin
          state <= ST_WRITE;
          idx   <= '0;
        end
        ST_WRITE: begin
          if (idx == LAST_IDX) begin
            state <= ST_SEARCH;
            idx   <= '0;
          end else idx <= idx + 1'b1;
        end
        ST_SEARCH: begin
          if (idx == LAST_IDX) begin
            idx <= '0;
            if (axis == AX_Z) state <= ST_FINISH;
            else begin
              axis  <= axisT'(axis + 2'd1);
              state <= ST_CLEAR;
            end
          end else idx <= idx + 1'b1;
        end
        ST_FINISH: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.initAcc   = (state == ST_IDLE) && start;
    strobe.clearCam  = (state == ST_CLEAR);
    strobe.writeCam  = (state == ST_WRITE);
    strobe.searchCam = (state == ST_SEARCH);
    strobe.publish   = (state == ST_FINISH);
    strobe.axis      = axis;
  end

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R2
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(cycleCount)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (cycleCount == CNT_W'($past(cycleCount) + 1'b1))); // R7

endmodule

// File: rtl/coord_screen_dp.sv
module coord_screen_dp
  import coord_screen_pkg::*;
#(
  parameter int NUM_TGT = 16,
  parameter int COORD_W = 32,
  localparam int IDX_W = $clog2(NUM_TGT),
  localparam int MASK_W = NUM_TGT * NUM_TGT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busy,
  input  logic               loadEn,
  input  logic [1:0]         loadAxis,
  input  logic [IDX_W-1:0]   loadIdx,
  input  logic [COORD_W-1:0] loadData,
  input  ctrlStrobeT         strobe,
  input  logic [IDX_W-1:0]   idx,
  output logic [MASK_W-1:0]  partnerMask,
  output logic               anyCollision
);

  logic [COORD_W-1:0] xCoord [NUM_TGT];
  logic [COORD_W-1:0] yCoord [NUM_TGT];
  logic [COORD_W-1:0] zCoord [NUM_TGT];
  logic [COORD_W-1:0] selCoord;
  logic [NUM_TGT-1:0] hitVec;
  logic [NUM_TGT-1:0] acc [NUM_TGT];
  logic [MASK_W-1:0]  nextMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_TGT; i++) begin
        xCoord[i] <= '0;
        yCoord[i] <= '0;
        zCoord[i] <= '0;
      end
    end else if (loadEn && !busy) begin
      case (loadAxis)
        2'd0:    xCoord[loadIdx] <= loadData;
        2'd1:    yCoord[loadIdx] <= loadData;
        2'd2:    zCoord[loadIdx] <= loadData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (strobe.axis)
      AX_X:    selCoord = xCoord[idx];
      AX_Y:    selCoord = yCoord[idx];
      default: selCoord = zCoord[idx];
    endcase
  end

  coord_cam #(.DEPTH(NUM_TGT), .WIDTH(COORD_W)) cam_i (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (strobe.clearCam),
    .wrEn   (strobe.writeCam),
    .wrIdx  (idx),
    .wrData (selCoord),
    .key    (selCoord),
    .hitVec (hitVec)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_TGT; i++) acc[i] <= '0;
    end else if (strobe.initAcc) begin
      for (int i = 0; i < NUM_TGT; i++) acc[i] <= '1;
    end else if (strobe.searchCam) begin
      acc[idx] <= acc[idx] & hitVec;
    end
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : gMask
    assign nextMask[g*NUM_TGT +: NUM_TGT] = acc[g] & ~(NUM_TGT'(1) << g);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partnerMask  <= '0;
      anyCollision <= 1'b0;
    end else if (strobe.publish) begin
      partnerMask  <= nextMask;
      anyCollision <= |nextMask;
    end
  end

  AST_OWN_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.searchCam |-> hitVec[idx]); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.publish |=> $stable(partnerMask)); // R8
  AST_ANY_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.publish |=> (anyCollision == (|partnerMask))); // R5

endmodule

// File: rtl/coord_screen_top.sv
module coord_screen_top
  import coord_screen_pkg::*;
#(
  parameter int NUM_TGT = 16,
  parameter int COORD_W = 32,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(NUM_TGT),
  localparam int MASK_W = NUM_TGT * NUM_TGT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [1:0]         loadAxis,
  input  logic [IDX_W-1:0]   loadIdx,
  input  logic [COORD_W-1:0] loadData,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [MASK_W-1:0]  partnerMask,
  output logic               anyCollision,
  output logic [CNT_W-1:0]   cycleCount
);

  ctrlStrobeT       strobe;
  logic [IDX_W-1:0] idx;

  coord_screen_ctrl #(.NUM_TGT(NUM_TGT), .CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .strobe     (strobe),
    .idx        (idx),
    .busy       (busy),
    .done       (done),
    .cycleCount (cycleCount)
  );

  coord_screen_dp #(.NUM_TGT(NUM_TGT), .COORD_W(COORD_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .busy         (busy),
    .loadEn       (loadEn),
    .loadAxis     (loadAxis),
    .loadIdx      (loadIdx),
    .loadData     (loadData),
    .strobe       (strobe),
    .idx          (idx),
    .partnerMask  (partnerMask),
    .anyCollision (anyCollision)
  );

endmodule

// File: tb/coord_screen_top_tb_top.sv
module coord_screen_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_TGT = 16;
  localparam int COORD_W = 32;
  localparam int CNT_W = 32;
  localparam int IDX_W = $clog2(NUM_TGT);
  localparam int MASK_W = NUM_TGT * NUM_TGT;
  localparam int RUN_LEN = 3 * (2 * NUM_TGT + 1) + 1;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               loadEn = 1'b0;
  logic [1:0]         loadAxis = '0;
  logic [IDX_W-1:0]   loadIdx = '0;
  logic [COORD_W-1:0] loadData = '0;
  logic               start = 1'b0;
  logic               busy, done, anyCollision;
  logic [MASK_W-1:0]  partnerMask;
  logic [CNT_W-1:0]   cycleCount;

  int nChecks = 0;
  int nFails = 0;

  // reference model state
  logic [COORD_W-1:0] mX [NUM_TGT];
  logic [COORD_W-1:0] mY [NUM_TGT];
  logic [COORD_W-1:0] mZ [NUM_TGT];
  bit                 mBusy, mDone, mAny;
  int                 mCnt, mLeft;
  logic [MASK_W-1:0]  mMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  coord_screen_top dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAxis(loadAxis),
    .loadIdx(loadIdx), .loadData(loadData), .start(start), .busy(busy),
    .done(done), .partnerMask(partnerMask), .anyCollision(anyCollision),
    .cycleCount(cycleCount)
  );

  task automatic chk(input bit ok, input string tag, input logic [MASK_W-1:0] act,
                     input logic [MASK_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, same edge as the design
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mAny = 0; mCnt = 0; mLeft = 0; mMask = '0;
      for (int i = 0; i < NUM_TGT; i++) begin mX[i] = 0; mY[i] = 0; mZ[i] = 0; end
    end else begin
      if (loadEn && !mBusy) begin
        if (loadAxis == 2'd0) mX[loadIdx] = loadData;
        else if (loadAxis == 2'd1) mY[loadIdx] = loadData;
        else if (loadAxis == 2'd2) mZ[loadIdx] = loadData;
      end
      if (mBusy) begin
        mCnt++;
        mLeft--;
        if (mLeft == 0) begin
          mBusy = 0;
          mDone = 1;
          mMask = '0;
          for (int i = 0; i < NUM_TGT; i++)
            for (int j = 0; j < NUM_TGT; j++)
              if (i != j && mX[i] == mX[j] && mY[i] == mY[j] && mZ[i] == mZ[j])
                mMask[i*NUM_TGT + j] = 1'b1;
          mAny = |mMask;
        end
      end else if (start) begin
        mBusy = 1; mDone = 0; mCnt = 0; mLeft = RUN_LEN;
      end
    end
  end

  // every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(busy == mBusy, "R2 busy", MASK_W'(busy), MASK_W'(mBusy));
      chk(done == mDone, "R2 done", MASK_W'(done), MASK_W'(mDone));
      chk(cycleCount == CNT_W'(mCnt), "R6 cycleCount", MASK_W'(cycleCount), MASK_W'(mCnt));
      chk(partnerMask == mMask, "R3 partnerMask", partnerMask, mMask);
      chk(anyCollision == mAny, "R5 anyCollision", MASK_W'(anyCollision), MASK_W'(mAny));
    end
  end

  task automatic loadOne(input int ax, input int t, input logic [COORD_W-1:0] v);
    @(negedge clk);
    loadEn = 1'b1; loadAxis = 2'(ax); loadIdx = IDX_W'(t); loadData = v;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic loadTgt(input int t, input logic [COORD_W-1:0] x, y, z);
    loadOne(0, t, x); loadOne(1, t, y); loadOne(2, t, z);
  endtask

  task automatic loadDistinct();
    for (int t = 0; t < NUM_TGT; t++)
      loadTgt(t, COORD_W'(t * 3 + 1), COORD_W'(t * 5 + 100), COORD_W'(t * 7 + 1000));
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    repeat (RUN_LEN + 2) @(negedge clk);
  endtask

  function automatic logic [MASK_W-1:0] pairBits(input int a, input int b);
    logic [MASK_W-1:0] m = '0;
    m[a*NUM_TGT + b] = 1'b1;
    m[b*NUM_TGT + a] = 1'b1;
    return m;
  endfunction

  initial begin
    logic [MASK_W-1:0] expM, held;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy == 0 && done == 0 && anyCollision == 0 && cycleCount == 0 && partnerMask == 0,
        "R9 reset state", partnerMask | MASK_W'(cycleCount), '0);
    rstN = 1'b1;

    // all distinct: no partners
    loadDistinct();
    pulseStart();
    waitDone();
    chk(partnerMask == '0 && !anyCollision, "R3 distinct targets", partnerMask, '0);
    chk(cycleCount == CNT_W'(RUN_LEN), "R6 run length", MASK_W'(cycleCount), MASK_W'(RUN_LEN));

    // targets 0 and 2 coincide; target 5 matches 0 on x and y only
    loadTgt(2, 32'd1, 32'd100, 32'd1000);
    loadTgt(5, 32'd1, 32'd100, 32'd4242);
    pulseStart();
    waitDone();
    chk(partnerMask == pairBits(0, 2), "R3 single pair, two-axis miss", partnerMask, pairBits(0, 2));

    // R8 hold over idle cycles
    held = partnerMask;
    repeat (7) @(negedge clk);
    chk(partnerMask == held && done && anyCollision, "R8 results hold", partnerMask, held);

    // three-way group 3,7,15 and pair 8,9; R7 start pulses mid-run
    loadDistinct();
    for (int t = 0; t < 3; t++) begin
      automatic int k = (t == 0) ? 3 : (t == 1) ? 7 : 15;
      loadTgt(k, 32'hDEAD_0000, 32'h0000_BEEF, 32'h1234_5678);
    end
    loadTgt(8, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000);
    loadTgt(9, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000);
    pulseStart();
    @(negedge clk);
    chk(done == 0 && busy == 1, "R8 done cleared by start", MASK_W'(done), '0);
    repeat (20) @(negedge clk);
    pulseStart();
    repeat (30) @(negedge clk);
    pulseStart();
    waitDone();
    expM = pairBits(3, 7) | pairBits(3, 15) | pairBits(7, 15) | pairBits(8, 9);
    chk(partnerMask == expM, "R3 group and pair", partnerMask, expM);
    chk(cycleCount == CNT_W'(RUN_LEN), "R7 mid-run start ignored", MASK_W'(cycleCount), MASK_W'(RUN_LEN));

    // all identical: every partner set, own bit clear
    for (int t = 0; t < NUM_TGT; t++) loadTgt(t, 32'h5, 32'h6, 32'h7);
    pulseStart();
    waitDone();
    for (int i = 0; i < NUM_TGT; i++)
      chk(partnerMask[i*NUM_TGT + i] == 1'b0, "R4 own bit clear", MASK_W'(partnerMask[i*NUM_TGT + i]), '0);
    expM = '1;
    for (int i = 0; i < NUM_TGT; i++) expM[i*NUM_TGT + i] = 1'b0;
    chk(partnerMask == expM && anyCollision, "R5 all coincide", partnerMask, expM);

    // R1 loads during a run are ignored; axis code 3 stores nothing
    loadDistinct();
    pulseStart();
    repeat (5) @(negedge clk);
    loadTgt(1, 32'd1, 32'd100, 32'd1000);
    waitDone();
    chk(partnerMask == '0, "R1 busy load ignored", partnerMask, '0);
    pulseStart();
    waitDone();
    chk(partnerMask == '0 && !anyCollision, "R1 busy load not kept", partnerMask, '0);
    loadOne(3, 4, 32'd1);
    loadOne(3, 4, 32'd100);
    pulseStart();
    waitDone();
    chk(partnerMask == '0, "R1 axis code 3 stores nothing", partnerMask, '0);
    loadTgt(1, 32'd1, 32'd100, 32'd1000);
    pulseStart();
    waitDone();
    chk(partnerMask == pairBits(0, 1), "R1 idle load applied", partnerMask, pairBits(0, 1));

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule